// File: doc/BRIEF.md
# Adjacent-Error Correcting Memory Word Codec

A combinational encoder and decoder for protecting a 16-bit memory word against particle strikes that upset neighbouring cells. The encoder appends 12 check bits to the data and produces a 28-bit stored word. The decoder takes a 28-bit word read back from storage. It corrects an error on any single bit, and it corrects an error on any two neighbouring bits. It flags an error on any two non-neighbouring bits, and on any three neighbouring bits, as uncorrectable and never miscorrects them.

The code is a polynomial code. The stored word, read as a polynomial with bit p as the coefficient of x^p, is always a multiple of g(x) = x^12+x^11+x^9+x^7+x^6+x^3+x^2+1. This is the product of a double-error-correcting generator of length 31 and (x+1)^2, so any two code words differ in at least six positions. The check-matrix column of bit p is x^p mod g(x). The decoder forms the 12-bit syndrome and compares it in parallel against all 28 single-bit columns and all 27 neighbour-pair sums. It drives each bit of a flip mask as the OR of the three matches that involve that bit, and XORs the mask into the received word.

Top module: `dae_codec`

## Requirements
- R1: In the encoded word, bits 27:12 equal the data input bits 15:0 and bits 11:0 hold the check bits.
- R2: Every encoded word, read as a polynomial (bit p is the coefficient of x^p), is divisible by g(x) = x^12+x^11+x^9+x^7+x^6+x^3+x^2+1 (binary 1_1010_1100_1101).
- R3: A received word that is a valid code word gives error flag 0, corrected flag 0 and uncorrectable flag 0, and the output word equals the input word.
- R4: A received word with exactly one bit inverted, at any of the 28 positions, is restored to the code word with error flag 1, corrected flag 1 and uncorrectable flag 0.
- R5: A received word with bits p and p+1 inverted, for any p from 0 to 26, is restored to the code word with error flag 1, corrected flag 1 and uncorrectable flag 0.
- R6: A received word with bits p, p+1 and p+2 inverted, for any p from 0 to 25, gives error flag 1, uncorrectable flag 1 and corrected flag 0, and the output word equals the received word unmodified.
- R7: A received word with two non-neighbouring bits inverted gives error flag 1, uncorrectable flag 1 and corrected flag 0, and the output word equals the received word.
- R8: Corrected and uncorrectable are never both 1, and either one being 1 implies the error flag is 1.
- R9: The decoder never inverts more than two bits, and when it inverts two they are neighbours.
- R10: The data output always equals bits 27:12 of the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 16 | Data word to encode |
| enc_word_o | output | 28 | Encoded word: data in 27:12, check bits in 11:0 |
| dec_word_i | input | 28 | Word read back from storage |
| dec_word_o | output | 28 | Received word with the correction mask applied |
| dec_data_o | output | 16 | Data field of the corrected word |
| dec_err_o | output | 1 | Syndrome is non-zero |
| dec_fix_o | output | 1 | One bit or one neighbouring pair was inverted back |
| dec_ue_o | output | 1 | Error seen that the decoder cannot correct |

## Verification
The assertions check on every evaluation that the flip mask has the allowed shape and that at most one single or pair match is active, which shows the columns and pair sums are distinct for whatever syndrome appears. They also check that the flags are consistent, that an uncorrectable word passes through untouched, and that the encoder output looped straight into the decoder is clean. Only the bench's scenarios can show that correction lands on the right bits and that every neighbouring triple and sampled non-neighbouring double is rejected rather than miscorrected. The bench does this by sweeping every single, pair and triple position over several data words and checking the encoded words for divisibility by g(x).

// File: rtl/dae_pkg.sv
package dae_pkg;

  localparam int DATA_W = 16;
  localparam int CHK_W  = 12;
  localparam int WORD_W = DATA_W + CHK_W;

  // Low 12 coefficients of the degree-12 generator; x^12 is implied.
  localparam logic [CHK_W-1:0] GEN_LOW = 12'hACD;

  typedef logic [CHK_W-1:0] syn_t;

  // Column of the check matrix for bit position pos: x^pos mod g(x).
  function automatic syn_t col_of(input int pos);
    syn_t v;
    v = syn_t'(1);
    for (int k = 0; k < pos; k++) begin
      if (v[CHK_W-1]) v = (v << 1) ^ GEN_LOW;
      else            v = v << 1;
    end
    return v;
  endfunction

endpackage

// File: rtl/dae_syndrome.sv
module dae_syndrome
  import dae_pkg::*;
#(
  parameter int N = WORD_W
) (
  input  logic [N-1:0] word_i,
  output syn_t         syn_o
);

  syn_t term [N];

  for (genvar p = 0; p < N; p++) begin : g_col
    localparam syn_t COL = col_of(p);
    assign term[p] = word_i[p] ? COL : '0;
  end

  always_comb begin
    syn_o = '0;
    for (int p = 0; p < N; p++) begin
      syn_o = syn_o ^ term[p];
    end
  end

endmodule

// File: rtl/dae_encoder.sv
module dae_encoder
  import dae_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int NW = DW + CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [NW-1:0] word_o
);

  syn_t chk;

  // Check columns are unit vectors, so the check bits equal the
  // syndrome contributed by the data bits alone.
  dae_syndrome #(.N(NW)) u_syn (
    .word_i ({data_i, {CHK_W{1'b0}}}),
    .syn_o  (chk)
  );

  assign word_o = {data_i, chk};

endmodule

// File: rtl/dae_flip_decoder.sv
module dae_flip_decoder
  import dae_pkg::*;
#(
  parameter int N = WORD_W
) (
  input  syn_t         syn_i,
  output logic [N-1:0] mask_o
);

  logic [N-1:0] hit_one;
  logic [N-2:0] hit_two;

  for (genvar p = 0; p < N; p++) begin : g_one
    localparam syn_t C1 = col_of(p);
    assign hit_one[p] = (syn_i == C1);
  end

  for (genvar p = 0; p < N - 1; p++) begin : g_two
    localparam syn_t C2 = col_of(p) ^ col_of(p + 1);
    assign hit_two[p] = (syn_i == C2);
  end

  for (genvar i = 0; i < N; i++) begin : g_mask
    if (i == 0) begin : g_lo
      assign mask_o[i] = hit_one[i] | hit_two[i];
    end else if (i == N - 1) begin : g_hi
      assign mask_o[i] = hit_one[i] | hit_two[i-1];
    end else begin : g_mid
      assign mask_o[i] = hit_one[i] | hit_two[i] | hit_two[i-1];
    end
  end

  always_comb begin
    // R5
    match_unique_chk: assert ($onehot0({hit_one, hit_two}))
      else $error("more than one syndrome match");
    // R9
    mask_shape_chk: assert (($countones(mask_o) < 2) ||
                            (($countones(mask_o) == 2) && ((mask_o & (mask_o >> 1)) != '0)))
      else $error("flip mask not a single bit or neighbour pair");
  end

endmodule

// File: rtl/dae_codec.sv
module dae_codec
  import dae_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int NW = DW + CHK_W
) (
  input  logic [DW-1:0] enc_data_i,
  output logic [NW-1:0] enc_word_o,
  input  logic [NW-1:0] dec_word_i,
  output logic [NW-1:0] dec_word_o,
  output logic [DW-1:0] dec_data_o,
  output logic          dec_err_o,
  output logic          dec_fix_o,
  output logic          dec_ue_o
);

  syn_t          syn;
  logic [NW-1:0] mask;

  dae_encoder #(.DW(DW)) u_enc (
    .data_i (enc_data_i),
    .word_o (enc_word_o)
  );

  dae_syndrome #(.N(NW)) u_syn (
    .word_i (dec_word_i),
    .syn_o  (syn)
  );

  dae_flip_decoder #(.N(NW)) u_flip (
    .syn_i  (syn),
    .mask_o (mask)
  );

  assign dec_word_o = dec_word_i ^ mask;
  assign dec_data_o = dec_word_o[NW-1:CHK_W];
  assign dec_err_o  = |syn;
  assign dec_fix_o  = |mask;
  assign dec_ue_o   = dec_err_o & ~dec_fix_o;

  always_comb begin
    // R8
    flag_excl_chk: assert (!(dec_fix_o && dec_ue_o) && (!dec_fix_o || dec_err_o))
      else $error("inconsistent flags");
    // R6
    ue_keep_chk: assert (!dec_ue_o || (dec_word_o == dec_word_i))
      else $error("uncorrectable word was modified");
    // R3
    loop_clean_chk: assert ((dec_word_i != enc_word_o) || (!dec_err_o && (dec_data_o == enc_data_i)))
      else $error("fresh code word not clean");
  end

endmodule

// File: tb/sim_dae_codec.sv
module sim_dae_codec;

  localparam int DW = 16;
  localparam int NW = 28;
  localparam int NT = 12;
  localparam logic [12:0] GEN = 13'h1ACD;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [DW-1:0] enc_data_i;
  logic [NW-1:0] enc_word_o;
  logic [NW-1:0] dec_word_i;
  logic [NW-1:0] dec_word_o;
  logic [DW-1:0] dec_data_o;
  logic          dec_err_o, dec_fix_o, dec_ue_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dae_codec u0 (
    .enc_data_i (enc_data_i),
    .enc_word_o (enc_word_o),
    .dec_word_i (dec_word_i),
    .dec_word_o (dec_word_o),
    .dec_data_o (dec_data_o),
    .dec_err_o  (dec_err_o),
    .dec_fix_o  (dec_fix_o),
    .dec_ue_o   (dec_ue_o)
  );

  // class codes: 0 clean, 1 correctable, 2 uncorrectable
  localparam logic [DW-1:0] TV_DATA [NT] = '{
    16'h0000, 16'hFFFF, 16'h1234, 16'h1234, 16'hBEEF, 16'hBEEF,
    16'h0F0F, 16'h0F0F, 16'h8001, 16'h8001, 16'h5555, 16'hAAAA };
  localparam logic [NW-1:0] TV_ERR [NT] = '{
    28'h0000000, 28'h0000000, 28'h0000001, 28'h8000000, 28'h0003000, 28'h0001800,
    28'hC000000, 28'h0000007, 28'hE000000, 28'h8000001, 28'h0000028, 28'h0001C00 };
  localparam logic [1:0] TV_CLASS [NT] = '{
    2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2 };

  function automatic logic [11:0] rem_of(input logic [NW-1:0] w);
    logic [12:0] r;
    r = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      r = {r[11:0], w[i]};
      if (r[12]) r = r ^ GEN;
    end
    return r[11:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic encode(input logic [DW-1:0] d, output logic [NW-1:0] cw);
    @(negedge clk);
    enc_data_i = d;
    #1;
    cw = enc_word_o;
    chk(cw[NW-1:12] == d, "R1 data field", {12'h0, cw[NW-1:12]}, {12'h0, d});
    chk(rem_of(cw) == 12'h0, "R2 divisible", {16'h0, rem_of(cw)}, '0);
  endtask

  task automatic decode(input logic [NW-1:0] cw, input logic [NW-1:0] e, input logic [1:0] cls, input string tag);
    logic [NW-1:0] rx;
    logic [NW-1:0] want;
    rx = cw ^ e;
    @(negedge clk);
    dec_word_i = rx;
    @(posedge clk);
    #1;
    want = (cls == 2'd2) ? rx : cw;
    chk(dec_word_o == want, {tag, " word"}, dec_word_o, want);
    chk(dec_data_o == want[NW-1:12], "R10 data out", {12'h0, dec_data_o}, {12'h0, want[NW-1:12]});
    chk({dec_err_o, dec_fix_o, dec_ue_o} == {cls != 2'd0, cls == 2'd1, cls == 2'd2},
        {tag, " flags R8"}, {25'h0, dec_err_o, dec_fix_o, dec_ue_o},
        {25'h0, cls != 2'd0, cls == 2'd1, cls == 2'd2});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NW-1:0] cw;
    logic [DW-1:0] dv [6];
    enc_data_i = '0;
    dec_word_i = '0;
    dv = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0001, 16'h8000, 16'h6D2B};

    // zero inputs: all-zero word is a code word (R3)
    @(negedge clk);
    #1;
    chk(enc_word_o == '0, "R3 zero encode", enc_word_o, '0);
    chk(!dec_err_o && !dec_fix_o && !dec_ue_o, "R3 zero flags",
        {25'h0, dec_err_o, dec_fix_o, dec_ue_o}, '0);

    // table walk
    for (int t = 0; t < NT; t++) begin
      encode(TV_DATA[t], cw);
      decode(cw, TV_ERR[t], TV_CLASS[t],
             TV_CLASS[t] == 2'd0 ? "R3 table" : (TV_CLASS[t] == 2'd1 ? "R5 table" : "R6 table"));
    end

    // sweeps over data words
    for (int k = 0; k < 6; k++) begin
      encode(dv[k], cw);
      decode(cw, '0, 2'd0, "R3 clean");
      for (int p = 0; p < NW; p++)
        decode(cw, NW'(1) << p, 2'd1, "R4 single");
      for (int p = 0; p < NW - 1; p++)
        decode(cw, NW'(3) << p, 2'd1, "R5 pair");
      for (int p = 0; p < NW - 2; p++)
        decode(cw, NW'(7) << p, 2'd2, "R6 triple");
      for (int n = 0; n < 12; n++) begin
        int a;
        int b;
        a = int'($urandom % NW);
        b = int'($urandom % NW);
        if (b == a || b == a + 1 || b + 1 == a) b = (a + 5) % NW;
        decode(cw, (NW'(1) << a) | (NW'(1) << b), 2'd2, "R7 double");
      end
    end

    // random data words, mixed patterns (R9 checked through exact word compare)
    for (int n = 0; n < 20; n++) begin
      int p;
      encode(DW'($urandom), cw);
      p = int'($urandom % (NW - 1));
      decode(cw, NW'(3) << p, 2'd1, "R9 rand pair");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule